// File: doc/BRIEF.md
# Double-Buffered Frame Pointer Controller

This block holds the two frame-buffer base addresses of a raster display engine. One is the pointer the display is scanning out; the other is the pointer software draws into. Software reaches both through four 32-bit registers on a simple word-addressed register bus. The bus has an address, write and read strobes, write data and registered read data. The block also reports the screen resolution and the pixel-format parameters.

A write with bit 0 set to the display-pointer register does not load that register. It arms a deferred exchange of the two pointers. The exchange happens on the next one-cycle vertical-sync pulse, so the scanned-out image never changes in the middle of a frame. A status bit stays high while the exchange is armed and drops once it has been carried out. Software polls that bit and, once it is low, starts drawing into the buffer that was just released.

Word index 0 is the display pointer. Index 1 is the drawing pointer. Index 2 is the resolution. Index 3 is the format and status. These correspond to byte offsets 0, 4, 8 and 12.

Top module: `fb_swap_ctrl`

## Requirements
- R1: After reset the display pointer is FRONT_RST (0x0800_0000), the drawing pointer is BACK_RST (0x0900_0000), the swap status bit is 0, the bytes-per-pixel field is 2 and the addressing-mode bit is 0.
- R2: A write to index 0 with bit 0 = 1 sets the status bit (index 3, bit 0) from the next cycle on. It leaves the display pointer unchanged.
- R3: A write to index 0 with bit 0 = 0 has no effect on either pointer or on the status bit.
- R4: On a vertical-sync pulse while the swap is armed, from the next cycle the display pointer holds the old drawing pointer, the drawing pointer holds the old display pointer, and the status bit is 0.
- R5: A vertical-sync pulse while no swap is armed changes neither pointer.
- R6: A second swap request made while one is armed merges with it, so a single sync pulse performs one exchange and clears the status.
- R7: When a write to index 1 falls in the same cycle as a swap, the swap happens first and the written value then lands in the drawing pointer. The display pointer takes the old drawing pointer.
- R8: A swap request in the same cycle as a swap-performing sync pulse arms a new swap, so the status bit reads 1 afterwards.
- R9: Index 2 reads the height RES_Y in bits 31-16 and the width RES_X in bits 15-0 (240 and 320 by default). Writes to it are ignored.
- R10: Index 3 reads the y-address bit count (8) in bits 31-24, the x-address bit count (9) in bits 23-16, bytes per pixel in bits 7-4, the addressing mode in bit 1 and the status in bit 0. All other bits read 0.
- R11: A write to index 3 always loads the addressing mode from bit 1. It loads bytes per pixel from bits 7-4 only when that value is 1 to 4; any other value keeps the old one. The bit counts cannot be written.
- R12: Read data appears on bus_rdata the cycle after a read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word index of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| vsync | input | 1 | One-cycle frame-boundary pulse |
| front_ptr | output | 32 | Pointer being scanned out |
| bytes_per_pix | output | 4 | Bytes per pixel, 1 to 4 |
| addr_mode | output | 1 | Addressing mode, 1 = x/y fields, 0 = linear |
| x_bits | output | 8 | Number of x address bits |
| y_bits | output | 8 | Number of y address bits |

## Verification
Two functions can coincide on one clock edge: the sync-triggered exchange and a bus write. The write can target either the drawing pointer or the swap request. The bench drives vsync in the same cycle as a drawing-pointer write and, separately, in the same cycle as a new swap request. It judges the first by reading both pointers back: the display pointer must hold the pre-swap drawing value and the drawing pointer the written value. It judges the second by the status bit still reading 1 and by a further pulse performing a second exchange.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
    localparam int REG_W = 32;
    localparam int IDX_W = 2;

    typedef enum logic [IDX_W-1:0] {
        SEL_FRONT = 2'd0,
        SEL_BACK  = 2'd1,
        SEL_RES   = 2'd2,
        SEL_FMT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] front;
        logic [REG_W-1:0] back;
    } ptr_state_t;

    typedef struct packed {
        logic [3:0] bpp;
        logic       amode;
    } fmt_state_t;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } rd_state_t;
endpackage

// File: rtl/fbc_bus_dec.sv
module fbc_bus_dec
    import fbc_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic [IDX_W-1:0] addr,
    input  logic             wr,
    input  logic             wdata_bit0,
    output logic             swap_req,
    output logic             wr_back,
    output logic             wr_fmt
);
    logic [NUM_REGS-1:0] hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = wr && (addr == IDX_W'(i));
    end

    assign swap_req = hit[SEL_FRONT] && wdata_bit0;
    assign wr_back  = hit[SEL_BACK];
    assign wr_fmt   = hit[SEL_FMT];
endmodule

// File: rtl/fbc_swap_sched.sv
module fbc_swap_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic vsync,
    output logic swap_now,
    output logic pending
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (vsync && pend_q) begin
            pend_d = 1'b0;
        end
        if (swap_req) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign swap_now = vsync && pend_q;
    assign pending  = pend_q;
endmodule

// File: rtl/fbc_ptr_bank.sv
module fbc_ptr_bank
    import fbc_pkg::*;
#(
    parameter logic [REG_W-1:0] FRONT_RST = 32'h0800_0000,
    parameter logic [REG_W-1:0] BACK_RST  = 32'h0900_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap_now,
    input  logic             wr_back,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] front,
    output logic [REG_W-1:0] back
);
    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swap_now) begin
            st_d.front = st_q.back;
            st_d.back  = st_q.front;
        end
        if (wr_back) begin
            st_d.back = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.front <= FRONT_RST;
            st_q.back  <= BACK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign front = st_q.front;
    assign back  = st_q.back;
endmodule

// File: rtl/fbc_fmt_reg.sv
module fbc_fmt_reg
    import fbc_pkg::*;
#(
    parameter logic [3:0] BPP_RST   = 4'd2,
    parameter logic       AMODE_RST = 1'b0,
    parameter int         BPP_MIN   = 1,
    parameter int         BPP_MAX   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_fmt,
    input  logic [3:0] wdata_bpp,
    input  logic       wdata_amode,
    output logic [3:0] bpp,
    output logic       amode
);
    localparam logic [3:0] LO = 4'(BPP_MIN);
    localparam logic [3:0] HI = 4'(BPP_MAX);

    fmt_state_t st_d, st_q;
    logic       bpp_ok;

    always_comb begin
        bpp_ok = (wdata_bpp >= LO) && (wdata_bpp <= HI);
        st_d   = st_q;
        if (wr_fmt) begin
            st_d.amode = wdata_amode;
            if (bpp_ok) begin
                st_d.bpp = wdata_bpp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bpp   <= BPP_RST;
            st_q.amode <= AMODE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bpp   = st_q.bpp;
    assign amode = st_q.amode;
endmodule

// File: rtl/fb_swap_ctrl.sv
module fb_swap_ctrl
    import fbc_pkg::*;
#(
    parameter logic [REG_W-1:0] FRONT_RST = 32'h0800_0000,
    parameter logic [REG_W-1:0] BACK_RST  = 32'h0900_0000,
    parameter int               RES_X     = 320,
    parameter int               RES_Y     = 240,
    parameter int               X_BITS    = 9,
    parameter int               Y_BITS    = 8,
    parameter int               BPP_RST   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             vsync,
    output logic [REG_W-1:0] front_ptr,
    output logic [3:0]       bytes_per_pix,
    output logic             addr_mode,
    output logic [7:0]       x_bits,
    output logic [7:0]       y_bits
);
    localparam logic [REG_W-1:0] RES_WORD = {16'(RES_Y), 16'(RES_X)};
    localparam logic [7:0]       XB       = 8'(X_BITS);
    localparam logic [7:0]       YB       = 8'(Y_BITS);

    logic             swap_req, wr_back, wr_fmt, swap_now, pending;
    logic [REG_W-1:0] back_ptr;
    rd_state_t        rd_d, rd_q;
    logic [REG_W-1:0] rd_mux;

    fbc_bus_dec #(.NUM_REGS(4)) u_dec (
        .addr       (bus_addr),
        .wr         (bus_wr),
        .wdata_bit0 (bus_wdata[0]),
        .swap_req   (swap_req),
        .wr_back    (wr_back),
        .wr_fmt     (wr_fmt)
    );

    fbc_swap_sched u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_req (swap_req),
        .vsync    (vsync),
        .swap_now (swap_now),
        .pending  (pending)
    );

    fbc_ptr_bank #(.FRONT_RST(FRONT_RST), .BACK_RST(BACK_RST)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_now (swap_now),
        .wr_back  (wr_back),
        .wdata    (bus_wdata),
        .front    (front_ptr),
        .back     (back_ptr)
    );

    fbc_fmt_reg #(.BPP_RST(4'(BPP_RST))) u_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fmt      (wr_fmt),
        .wdata_bpp   (bus_wdata[7:4]),
        .wdata_amode (bus_wdata[1]),
        .bpp         (bytes_per_pix),
        .amode       (addr_mode)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_FRONT: rd_mux = front_ptr;
            SEL_BACK:  rd_mux = back_ptr;
            SEL_RES:   rd_mux = RES_WORD;
            default:   rd_mux = {YB, XB, 8'h00, bytes_per_pix, 2'b00, addr_mode, pending};
        endcase
        rd_d = rd_q;
        if (bus_rd) begin
            rd_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q.rdata <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
    assign x_bits    = XB;
    assign y_bits    = YB;
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        vsync,
    input logic        pending,
    input logic        wr_back,
    input logic [31:0] wdata,
    input logic [31:0] front,
    input logic [31:0] back,
    input logic [3:0]  bpp
);
    AST_REQ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pending); // R2

    AST_SWAP_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && vsync) |=> (front == $past(back))); // R4

    AST_SWAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && vsync && !req) |=> !pending); // R4

    AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending && vsync) |=> $stable(front)); // R5

    AST_BACK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_back |=> (back == $past(wdata))); // R7

    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && vsync && req) |=> pending); // R8

    AST_BPP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bpp >= 4'd1) && (bpp <= 4'd4)); // R11
endmodule

bind fb_swap_ctrl fbc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (swap_req),
    .vsync   (vsync),
    .pending (pending),
    .wr_back (wr_back),
    .wdata   (bus_wdata),
    .front   (front_ptr),
    .back    (back_ptr),
    .bpp     (bytes_per_pix)
);

// File: tb/fb_swap_ctrl_bench.sv
module fb_swap_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vsync = 1'b0;
    logic [31:0] front_ptr;
    logic [3:0]  bytes_per_pix;
    logic        addr_mode;
    logic [7:0]  x_bits, y_bits;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    fb_swap_ctrl u_fb_swap_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vsync(vsync), .front_ptr(front_ptr), .bytes_per_pix(bytes_per_pix),
        .addr_mode(addr_mode), .x_bits(x_bits), .y_bits(y_bits)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data one edge after a read strobe
    always @(posedge clk) begin
        logic was_rd;
        was_rd = bus_rd;
        #2;
        if (was_rd) begin
            if (exp_q.size() == 0) begin
                check(bus_rdata, 32'hxxxx_xxxx, "R12 unexpected read");
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] d, input logic vs);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; vsync = vs;
        @(negedge clk);
        bus_wr = 1'b0; vsync = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(front_ptr, 32'h0800_0000, "R1 front");
        check({28'd0, bytes_per_pix}, 32'd2, "R1 bpp");
        check({31'd0, addr_mode}, 32'd0, "R1 amode");
        rd(2'd0, 32'h0800_0000, "R1 read front");
        rd(2'd1, 32'h0900_0000, "R1 read back");
        rd(2'd3, 32'h0809_0020, "R10 fmt/status reset");
        rd(2'd2, 32'h00F0_0140, "R9 resolution");
        // R5 sync with nothing armed
        cyc(1'b0, 2'd0, 32'h0, 1'b1);
        check(front_ptr, 32'h0800_0000, "R5 front unchanged");
        // R3 write of 0
        cyc(1'b1, 2'd0, 32'hFFFF_FFFE, 1'b0);
        check(front_ptr, 32'h0800_0000, "R3 front");
        rd(2'd3, 32'h0809_0020, "R3 status");
        // R2 request
        cyc(1'b1, 2'd0, 32'h1, 1'b0);
        check(front_ptr, 32'h0800_0000, "R2 front held");
        rd(2'd3, 32'h0809_0021, "R2 status set");
        // R6 second request merged, back written while armed
        cyc(1'b1, 2'd0, 32'h1, 1'b0);
        cyc(1'b1, 2'd1, 32'h0100_0000, 1'b0);
        rd(2'd1, 32'h0100_0000, "R6 back written");
        // R4 swap
        cyc(1'b0, 2'd0, 32'h0, 1'b1);
        check(front_ptr, 32'h0100_0000, "R4 front");
        rd(2'd1, 32'h0800_0000, "R4 back");
        rd(2'd3, 32'h0809_0020, "R4 status clear");
        cyc(1'b0, 2'd0, 32'h0, 1'b1);
        check(front_ptr, 32'h0100_0000, "R6 single swap");
        // R7 back write collides with swap
        cyc(1'b1, 2'd0, 32'h1, 1'b0);
        cyc(1'b1, 2'd1, 32'h0200_0000, 1'b1);
        check(front_ptr, 32'h0800_0000, "R7 front");
        rd(2'd1, 32'h0200_0000, "R7 back");
        rd(2'd3, 32'h0809_0020, "R7 status");
        // R8 request collides with swap
        cyc(1'b1, 2'd0, 32'h1, 1'b0);
        cyc(1'b1, 2'd0, 32'h1, 1'b1);
        check(front_ptr, 32'h0200_0000, "R8 front");
        rd(2'd3, 32'h0809_0021, "R8 rearmed");
        cyc(1'b0, 2'd0, 32'h0, 1'b1);
        check(front_ptr, 32'h0800_0000, "R8 second swap");
        rd(2'd3, 32'h0809_0020, "R8 status clear");
        // R9 resolution write ignored
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
        rd(2'd2, 32'h00F0_0140, "R9 write ignored");
        // R11 format writes
        cyc(1'b1, 2'd3, 32'hFFFF_0032, 1'b0);
        rd(2'd3, 32'h0809_0032, "R11 bpp3 amode1");
        check({28'd0, bytes_per_pix}, 32'd3, "R11 bpp port");
        check({31'd0, addr_mode}, 32'd1, "R11 amode port");
        cyc(1'b1, 2'd3, 32'h0000_0000, 1'b0);
        rd(2'd3, 32'h0809_0030, "R11 bpp0 rejected");
        cyc(1'b1, 2'd3, 32'h0000_0050, 1'b0);
        rd(2'd3, 32'h0809_0030, "R11 bpp5 rejected");
        cyc(1'b1, 2'd3, 32'h0000_0040, 1'b0);
        rd(2'd3, 32'h0809_0040, "R11 bpp4");
        check({24'd0, x_bits}, 32'd9, "R10 x bits");
        check({24'd0, y_bits}, 32'd8, "R10 y bits");
        // R12 hold between reads
        repeat (3) @(negedge clk);
        check(bus_rdata, 32'h0809_0040, "R12 rdata held");
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check(32'(exp_q.size()), 32'd0, "R12 reads left");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule